// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider for one loop of a frequency synthesizer. A dual-modulus prescaler sits in front of it and divides the oscillator signal by either P or P+1. The block counts the prescaler's output periods and drives the prescaler's modulus line. Over one full division cycle the oscillator is divided by P·N + A in total.

Two down-counters run side by side. The main counter spans N prescaler periods. The swallow counter keeps the prescaler at P+1 for the first A of those periods, and the prescaler divides by P for the remaining N−A periods. In the last period of each cycle the main counter sits at terminal count, and the block drives a compare pulse for exactly that one period.

A new ratio (N, A and a base-modulus select bit) may be written at any time. It waits in a holding register and both counters pick it up only at the next cycle boundary. An illegal ratio raises an error flag and is discarded.

The block runs on a system clock. Each prescaler output period arrives as a one-clock `pre_tick` strobe.

Top module: `pswl_divider`

## Requirements
- R1: With a prescaler that divides by `presc_base + mod_ctl`, the number of clock cycles between successive falling edges of `cmp_pulse` equals P·N + A for the active ratio.
- R2: Each division cycle contains exactly N accepted `pre_tick` strobes. `mod_ctl` is 1 during the first A of those prescaler periods and 0 during the other N−A.
- R3: When A is 0, `mod_ctl` stays 0 for the whole cycle.
- R4: `cmp_pulse` is high for exactly one prescaler period, the last one of each cycle, during which the prescaler divides by P (so it lasts P clock cycles).
- R5: `presc_base` gives P. With parameter `HI_LOOP`=0, `cfg_sel`=1 gives 16 and `cfg_sel`=0 gives 32. With `HI_LOOP`=1, they give 64 and 128. `presc_base` changes only at a cycle boundary.
- R6: A write (`cfg_we` high for one clock) takes effect at the first cycle boundary after it is registered. The cycle in progress completes with the old ratio. A write in the very clock of the boundary strobe applies only at the boundary after that.
- R7: A write with N < 5 or A ≥ N sets `cfg_err` on the next clock and leaves the ratio in use unchanged. A legal write clears `cfg_err`.
- R8: After reset `cmp_pulse`=0, `cfg_err`=0 and `mod_ctl`=0, and the default ratio is N=5, A=0, select=1 (`presc_base`=16 when `HI_LOOP`=0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_tick | input | 1 | One-clock strobe per prescaler output period |
| cfg_we | input | 1 | Write strobe for a new ratio |
| cfg_n | input | 11 | Main count N (5..2047) |
| cfg_a | input | 7 | Swallow count A (0..127, below N) |
| cfg_sel | input | 1 | Base modulus select (1 = smaller P) |
| mod_ctl | output | 1 | Prescaler modulus: 1 = P+1, 0 = P |
| cmp_pulse | output | 1 | Compare pulse, high during the final prescaler period |
| presc_base | output | 8 | Base modulus P for the active cycle |
| cfg_err | output | 1 | Result of the last write: 1 = rejected |

## Verification
The hardest case to reach is a ratio write that lands in the exact clock where the boundary strobe is accepted. At that edge the holding register and the counter reload both update. The bench waits at the falling edge for `cmp_pulse` and `pre_tick` to be high together, writes in that clock, and then expects two more cycles at the old ratio before the new one appears. A behavioural prescaler in the bench closes the loop, so the period length, the count of P+1 periods and the compare width are all measured against P·N + A. The ratios come from seeded random values mixed with directed edges: A = 0, A = N−1, the largest legal A, and both illegal forms.

// File: rtl/pswl_pkg.sv
// Shared widths, limits and the ratio record used by the divider blocks.
package pswl_pkg;
    localparam int unsigned MAIN_W   = 11;  // main counter width
    localparam int unsigned SWAL_W   = 7;   // swallow counter width
    localparam int unsigned BASE_W   = 8;   // width of reported base modulus
    localparam int unsigned MIN_MAIN = 5;   // smallest legal main count

    typedef struct packed {
        logic              band_sel;  // 1 = smaller base modulus
        logic [MAIN_W-1:0] main;      // N
        logic [SWAL_W-1:0] swal;      // A
    } ratio_t;
endpackage

// File: rtl/pswl_ratio_hold.sv
// Holding register for the next division ratio.
// Checks each write and keeps only legal ratios (N >= MIN_MAIN, A < N).
// Assumes wr_en is a one-clock strobe. err reflects the most recent write.
module pswl_ratio_hold
    import pswl_pkg::*;
#(
    parameter int unsigned RST_MAIN = 5,
    parameter int unsigned RST_SWAL = 0,
    parameter bit          RST_SEL  = 1'b1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  ratio_t wr_ratio,
    output ratio_t pend,
    output logic   err
);
    localparam int unsigned PAD_W = MAIN_W - SWAL_W;

    logic ratio_bad;

    // Legality check of the incoming ratio.
    always_comb begin
        ratio_bad = (wr_ratio.main < MAIN_W'(MIN_MAIN)) ||
                    ({{PAD_W{1'b0}}, wr_ratio.swal} >= wr_ratio.main);
    end

    // Capture legal ratios; record the verdict of every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend.band_sel <= RST_SEL;
            pend.main     <= MAIN_W'(RST_MAIN);
            pend.swal     <= SWAL_W'(RST_SWAL);
            err           <= 1'b0;
        end else if (wr_en) begin
            err <= ratio_bad;
            if (!ratio_bad) begin
                pend <= wr_ratio;
            end
        end
    end

    // R7: the held ratio is always a legal one
    p_pend_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.main >= MAIN_W'(MIN_MAIN)) && ({{PAD_W{1'b0}}, pend.swal} < pend.main));
endmodule

// File: rtl/pswl_main_ctr.sv
// Main down-counter: spans N prescaler periods per division cycle.
// at_term marks the last period. wrap is the boundary strobe that reloads.
// Assumes reload_n >= 2 so the counter always leaves terminal count.
module pswl_main_ctr
    import pswl_pkg::*;
#(
    parameter int unsigned RST_MAIN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [MAIN_W-1:0] reload_n,
    output logic              at_term,
    output logic              wrap
);
    logic [MAIN_W-1:0] cnt;

    // Terminal decode and boundary strobe.
    always_comb begin
        at_term = (cnt == '0);
        wrap    = adv && at_term;
    end

    // Count down one per prescaler period, reload from N-1 at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= MAIN_W'(RST_MAIN - 1);
        end else if (wrap) begin
            cnt <= reload_n - MAIN_W'(1);
        end else if (adv) begin
            cnt <= cnt - MAIN_W'(1);
        end
    end

    // R1: the count moves only on a prescaler period
    p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt));
    // R4: terminal count lasts a single prescaler period
    p_term_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> !at_term);
endmodule

// File: rtl/pswl_swallow_ctr.sv
// Swallow down-counter: holds the prescaler at P+1 while it is non-zero.
// Loaded with A at each boundary and decremented once per prescaler period.
// Assumes A < N, so it is empty before the next load.
module pswl_swallow_ctr
    import pswl_pkg::*;
#(
    parameter int unsigned RST_SWAL = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic [SWAL_W-1:0] reload_a,
    output logic              mod_hi
);
    logic [SWAL_W-1:0] cnt;

    // Modulus request while swallow periods remain.
    always_comb mod_hi = (cnt != '0);

    // Load at the boundary, otherwise count the swallow periods away.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= SWAL_W'(RST_SWAL);
        end else if (load) begin
            cnt <= reload_a;
        end else if (adv && mod_hi) begin
            cnt <= cnt - SWAL_W'(1);
        end
    end

    // R2: swallow periods are exhausted by the time the main counter wraps
    p_swallow_spent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !mod_hi);
    // R2: the P+1 request can start only at a boundary
    p_mod_rise_at_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_hi) |-> $past(load));
endmodule

// File: rtl/pswl_divider.sv
// Pulse-swallow feedback divider, top level.
// Divides the oscillator by P*N + A through a dual-modulus prescaler.
// The prescaler reports each output period as a one-clock pre_tick strobe.
// HI_LOOP selects the base modulus pair: 0 -> 16/32, 1 -> 64/128.
module pswl_divider
    import pswl_pkg::*;
#(
    parameter bit          HI_LOOP  = 1'b0,
    parameter int unsigned DEF_MAIN = 5,
    parameter int unsigned DEF_SWAL = 0,
    parameter bit          DEF_SEL  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_tick,
    input  logic              cfg_we,
    input  logic [MAIN_W-1:0] cfg_n,
    input  logic [SWAL_W-1:0] cfg_a,
    input  logic              cfg_sel,
    output logic              mod_ctl,
    output logic              cmp_pulse,
    output logic [BASE_W-1:0] presc_base,
    output logic              cfg_err
);
    localparam int unsigned BASE_SMALL = HI_LOOP ? 64 : 16;
    localparam int unsigned BASE_LARGE = 2 * BASE_SMALL;

    ratio_t wr_ratio;
    ratio_t pend;
    logic   at_term;
    logic   wrap;
    logic   sel_act;

    // Pack the write fields into a ratio record.
    always_comb begin
        wr_ratio.band_sel = cfg_sel;
        wr_ratio.main     = cfg_n;
        wr_ratio.swal     = cfg_a;
    end

    pswl_ratio_hold #(
        .RST_MAIN (DEF_MAIN),
        .RST_SWAL (DEF_SWAL),
        .RST_SEL  (DEF_SEL)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_ratio (wr_ratio),
        .pend     (pend),
        .err      (cfg_err)
    );

    pswl_main_ctr #(
        .RST_MAIN (DEF_MAIN)
    ) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (pre_tick),
        .reload_n (pend.main),
        .at_term  (at_term),
        .wrap     (wrap)
    );

    pswl_swallow_ctr #(
        .RST_SWAL (DEF_SWAL)
    ) u_swal (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (pre_tick),
        .load     (wrap),
        .reload_a (pend.swal),
        .mod_hi   (mod_ctl)
    );

    // Base-modulus select for the running cycle, switched only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_act <= DEF_SEL;
        end else if (wrap) begin
            sel_act <= pend.band_sel;
        end
    end

    // Map the select bit to the base modulus of the configured loop.
    generate
        if (HI_LOOP) begin : g_hi_loop
            always_comb presc_base = sel_act ? BASE_W'(BASE_SMALL) : BASE_W'(BASE_LARGE);
        end else begin : g_lo_loop
            always_comb presc_base = sel_act ? BASE_W'(BASE_SMALL) : BASE_W'(BASE_LARGE);
        end
    endgenerate

    // Compare output spans the terminal period of the main counter.
    always_comb cmp_pulse = at_term;

    // R5: base modulus never changes inside a cycle
    p_base_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(presc_base));
    // R4: the compare period runs at the plain modulus
    p_cmp_plain_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |-> !mod_ctl);
    // R6: a write never disturbs the running counters outside a boundary
    p_write_no_glitch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !pre_tick) |=> $stable(mod_ctl) && $stable(cmp_pulse));
endmodule

// File: tb/test_pswl_divider.sv
`timescale 1ns/1ps
module test_pswl_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [10:0] cfg_n = '0;
    logic [6:0]  cfg_a = '0;
    logic        cfg_sel = 1'b0;
    logic        mod_ctl;
    logic        cmp_pulse;
    logic [7:0]  presc_base;
    logic        cfg_err;

    int tests = 0;
    int fails = 0;
    int cur_n = 5, cur_a = 0, cur_sel = 1;

    pswl_divider i_pswl_divider (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .cfg_we(cfg_we),
        .cfg_n(cfg_n), .cfg_a(cfg_a), .cfg_sel(cfg_sel), .mod_ctl(mod_ctl),
        .cmp_pulse(cmp_pulse), .presc_base(presc_base), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    // Behavioural dual-modulus prescaler: one strobe every P or P+1 clocks.
    int pc = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            pc <= 0;
            pre_tick <= 1'b0;
        end else if (pc + 1 >= int'(presc_base) + int'(mod_ctl)) begin
            pc <= 0;
            pre_tick <= 1'b1;
        end else begin
            pc <= pc + 1;
            pre_tick <= 1'b0;
        end
    end

    // Cycle monitor: measures each division cycle between compare falls.
    logic prev_cmp = 1'b0;
    int cyc = 0, tk = 0, mh = 0, wd = 0, pb_cur = 0;
    int m_len = 0, m_tk = 0, m_mh = 0, m_wd = 0, m_pb = 0;
    int done_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cmp = 1'b0;
            cyc = 0; tk = 0; mh = 0; wd = 0;
        end else begin
            if (prev_cmp && !cmp_pulse) begin
                m_len = cyc; m_tk = tk; m_mh = mh; m_wd = wd; m_pb = pb_cur;
                cyc = 0; tk = 0; mh = 0; wd = 0;
                done_cnt++;
            end
            if (cmp_pulse && !prev_cmp) pb_cur = int'(presc_base);
            cyc++;
            if (pre_tick) tk++;
            if (pre_tick && mod_ctl) mh++;
            if (cmp_pulse) wd++;
            prev_cmp = cmp_pulse;
        end
    end

    // Watchdog.
    int wdog = 0;
    always @(posedge clk) begin
        wdog++;
        if (wdog == 190000) begin
            tests++; fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", wdog);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // Compare the last measured cycle against the expected ratio.
    task automatic check_cycle(input int n, input int a, input int sel, input string ctx);
        int p;
        p = sel ? 16 : 32;
        check(m_len == p * n + a, {ctx, " R1 cycle length"}, m_len, p * n + a);
        check(m_tk == n, {ctx, " R2 periods per cycle"}, m_tk, n);
        check(m_mh == a, a == 0 ? {ctx, " R3 P+1 periods"} : {ctx, " R2 P+1 periods"}, m_mh, a);
        check(m_wd == p, {ctx, " R4 compare width"}, m_wd, p);
        check(m_pb == p, {ctx, " R5 base modulus"}, m_pb, p);
    endtask

    task automatic drive(input int n, input int a, input int sel);
        cfg_n = 11'(n); cfg_a = 7'(a); cfg_sel = sel[0]; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Legal write just after a boundary: old cycle completes, then the new ratio.
    task automatic apply(input int n, input int a, input int sel, input string ctx);
        int s;
        s = done_cnt;
        drive(n, a, sel);
        check(cfg_err == 1'b0, {ctx, " R7 err clear"}, int'(cfg_err), 0);
        wait (done_cnt == s + 1);
        check_cycle(cur_n, cur_a, cur_sel, {ctx, " R6 old"});
        wait (done_cnt == s + 2);
        check_cycle(n, a, sel, ctx);
        cur_n = n; cur_a = a; cur_sel = sel;
    endtask

    // Write in the clock of the boundary strobe (R6 corner).
    task automatic apply_edge(input int n, input int a, input int sel);
        int s;
        do @(negedge clk); while (!(cmp_pulse && pre_tick));
        s = done_cnt;
        drive(n, a, sel);
        wait (done_cnt == s + 2);
        check_cycle(cur_n, cur_a, cur_sel, "R6 boundary write old");
        wait (done_cnt == s + 3);
        check_cycle(n, a, sel, "R6 boundary write new");
        cur_n = n; cur_a = a; cur_sel = sel;
    endtask

    // Illegal write: flag raised, ratio kept across a boundary.
    task automatic apply_bad(input int n, input int a, input int sel, input string ctx);
        int s;
        s = done_cnt;
        drive(n, a, sel);
        check(cfg_err == 1'b1, {ctx, " R7 err set"}, int'(cfg_err), 1);
        wait (done_cnt == s + 1);
        check_cycle(cur_n, cur_a, cur_sel, {ctx, " R7 held"});
        wait (done_cnt == s + 2);
        check_cycle(cur_n, cur_a, cur_sel, {ctx, " R7 held"});
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(cmp_pulse == 1'b0, "R8 reset cmp_pulse", int'(cmp_pulse), 0);
        check(cfg_err == 1'b0, "R8 reset cfg_err", int'(cfg_err), 0);
        check(mod_ctl == 1'b0, "R8 reset mod_ctl", int'(mod_ctl), 0);
        check(presc_base == 8'd16, "R8 reset presc_base", int'(presc_base), 16);
        rst_n = 1'b1;
        wait (done_cnt == 1);
        wait (done_cnt == 2);
        check_cycle(5, 0, 1, "R8 default ratio");

        apply(10, 3, 1, "directed");
        apply(5, 4, 0, "A=N-1");
        apply(12, 0, 0, "A=0");
        apply(128, 127, 1, "max A");
        apply_bad(6, 6, 1, "A=N");
        apply_bad(4, 0, 0, "N<5");
        apply(7, 2, 1, "after error");
        apply_edge(9, 5, 0);
        for (int i = 0; i < 12; i++) begin
            int n, a, sel;
            n = 5 + int'($urandom % 26);
            a = int'($urandom % 32'(n));
            sel = int'($urandom % 2);
            apply(n, a, sel, "random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule